// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Phase Accumulator

This block divides a fast clock, which stands in for the oscillator of a frequency synthesizer, by an integer N or by N+1, choosing the modulus afresh for every output period. A first-order phase accumulator of modulus F makes the choice. It gains the fractional word K once per output period. When the sum reaches F, it wraps and keeps the remainder, and that period is stretched to N+1 input cycles. Over any run of F periods the stretch happens exactly K times. The mean division ratio is therefore N + K/F, and the long/short pattern repeats every F periods.

The divider is fed from the fast clock domain. The integer ratio, fractional word and modulus are sampled only in the load cycle that opens each period, so software or a modulator may change them at any time. The divided output is a one-cycle pulse by default, or a near-50% square wave through a parameter. The overflow bit that set the current period is held as an output. A count of the input cycles left in the period is also brought out as a checking aid.

Top module: `fracn_divider`

## Requirements
- R1: While reset is low and in the first cycle after it is released, div_clk is 1, ovf_sel is 0, cycles_left is 0 and the accumulator holds zero, so the first load starts from an empty accumulator.
- R2: A cycle in which cycles_left is 0 is a load cycle. The next period then lasts L input cycles, with L equal to N or N+1. cycles_left counts down from L-1 by one per cycle and returns to 0 exactly L cycles after the previous load cycle.
- R3: In each load cycle the accumulator is summed with K. The period that starts there is N+1 long exactly when that sum is at least F, and ovf_sel shows that decision, 1 for N+1, from the next cycle through the whole period.
- R4: On wrap the accumulator keeps the remainder (sum minus F) and is not cleared. For example, with K=3 and F=8 the long periods are the 3rd, 6th and 8th of every eight.
- R5: With N, K and F held constant, every window of F consecutive periods holds exactly K periods of length N+1, and the pattern repeats with period F.
- R6: With K = 0 every period is exactly N cycles long and ovf_sel stays 0 (integer-N division).
- R7: Values on div_int, frac_k and acc_mod in cycles where cycles_left is not 0 have no effect on period lengths or on ovf_sel.
- R8: In the default pulse shape, div_clk is high for exactly one input cycle per period, the load cycle, and low in all other cycles.
- R9: With K = F-1, exactly F-1 of every F periods are N+1 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk_fast |
| div_int | input | NW | Integer ratio N, at least 4, sampled in the load cycle |
| frac_k | input | AW | Fractional word K, below acc_mod, sampled in the load cycle |
| acc_mod | input | AW | Accumulator modulus F, sampled in the load cycle |
| div_clk | output | 1 | Divided clock: pulse in the load cycle, or square wave |
| ovf_sel | output | 1 | 1 while the current period is N+1 long |
| cycles_left | output | NW+1 | Input cycles left in the current period, 0 in the load cycle |

## Verification
On every cycle the assertions check the following. The cycle count steps down by one between loads. Each period is at least the minimum length. The modulus select holds still within a period. The accumulator stays below the latched modulus. A pulse never lasts two cycles. Legal N and K are checked at each load. The exact long/short sequence depends on arithmetic over many periods, and so do the remainder carried through a wrap, the K-in-F count and the immunity to mid-period input changes. Only the bench scenarios show these, by comparing against an accumulator model kept in the bench.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
   localparam int unsigned MIN_DIV = 4;

   typedef enum logic {
      SHAPE_PULSE  = 1'b0,
      SHAPE_SQUARE = 1'b1
   } out_shape_e;
endpackage

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] k_in,
   input  logic [AW-1:0] f_in,
   output logic          sel_next,
   output logic          sel_q
);
   localparam int unsigned SW = AW + 1;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] f_lat_q;
   logic [SW-1:0] sum;
   logic [SW-1:0] wrapped;

   always_comb begin
      sum      = {1'b0, acc_q} + {1'b0, k_in};
      sel_next = (sum >= {1'b0, f_in});
      wrapped  = sel_next ? (sum - {1'b0, f_in}) : sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         sel_q   <= 1'b0;
         f_lat_q <= '0;
      end else if (load) begin
         acc_q   <= wrapped[AW-1:0];
         sel_q   <= sel_next;
         f_lat_q <= f_in;
      end
   end

   // R3: the select only changes at a load
   p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(sel_q));
   // R4: the carried remainder stays below the latched modulus
   p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (f_lat_q != '0) |-> (acc_q < f_lat_q));
   // R3: the fractional word must be below the modulus when sampled
   p_legal_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (k_in < f_in));
endmodule

// File: rtl/fracdiv_count.sv
module fracdiv_count #(
   parameter int unsigned NW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [NW:0] len,
   output logic        load,
   output logic [NW:0] rem_q,
   output logic [NW:0] cur_len_q
);
   assign load = (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q     <= '0;
         cur_len_q <= '0;
      end else if (load) begin
         rem_q     <= len - 1'b1;
         cur_len_q <= len;
      end else begin
         rem_q     <= rem_q - 1'b1;
      end
   end

   // R2: steady countdown between loads
   p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));
   // R2: a period is never shorter than the minimum ratio
   p_min_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rem_q >= (NW+1)'(fracdiv_pkg::MIN_DIV - 1)));
endmodule

// File: rtl/fracdiv_shape.sv
module fracdiv_shape #(
   parameter int unsigned           NW    = 8,
   parameter fracdiv_pkg::out_shape_e SHAPE = fracdiv_pkg::SHAPE_PULSE
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [NW:0] rem,
   input  logic [NW:0] cur_len,
   output logic        div_o
);
   generate
      if (SHAPE == fracdiv_pkg::SHAPE_PULSE) begin : g_pulse
         assign div_o = (rem == '0);
         // R8: the pulse never lasts two cycles
         p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            div_o |=> !div_o);
      end else begin : g_square
         // high from the load cycle through the first ceil(L/2) cycles
         assign div_o = (rem == '0) || (rem > (cur_len >> 1));
      end
   endgenerate
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider #(
   parameter int unsigned             NW        = 8,
   parameter int unsigned             AW        = 10,
   parameter fracdiv_pkg::out_shape_e OUT_SHAPE = fracdiv_pkg::SHAPE_PULSE
) (
   input  logic          clk_fast,
   input  logic          rst_n,
   input  logic [NW-1:0] div_int,
   input  logic [AW-1:0] frac_k,
   input  logic [AW-1:0] acc_mod,
   output logic          div_clk,
   output logic          ovf_sel,
   output logic [NW:0]   cycles_left
);
   localparam int unsigned LW = NW + 1;

   generate
      if (NW < 3) begin : g_bad_nw
         $fatal(1, "NW must hold the minimum ratio");
      end
      if (AW < 2) begin : g_bad_aw
         $fatal(1, "AW must be at least 2");
      end
   endgenerate

   logic          load;
   logic          sel_next;
   logic [LW-1:0] len;
   logic [LW-1:0] rem;
   logic [LW-1:0] cur_len;

   assign len = {1'b0, div_int} + {{NW{1'b0}}, sel_next};

   fracdiv_accum #(.AW(AW)) u_accum (
      .clk      (clk_fast),
      .rst_n    (rst_n),
      .load     (load),
      .k_in     (frac_k),
      .f_in     (acc_mod),
      .sel_next (sel_next),
      .sel_q    (ovf_sel)
   );

   fracdiv_count #(.NW(NW)) u_count (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .len       (len),
      .load      (load),
      .rem_q     (rem),
      .cur_len_q (cur_len)
   );

   fracdiv_shape #(.NW(NW), .SHAPE(OUT_SHAPE)) u_shape (
      .clk     (clk_fast),
      .rst_n   (rst_n),
      .rem     (rem),
      .cur_len (cur_len),
      .div_o   (div_clk)
   );

   assign cycles_left = rem;

   // R2: the integer ratio must meet the minimum when sampled
   p_min_n_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
      load |-> (div_int >= NW'(fracdiv_pkg::MIN_DIV)));
endmodule

// File: tb/fracn_divider_tb_top.sv
module fracn_divider_tb_top;
   localparam int NW = 8;
   localparam int AW = 10;

   logic          clk_fast = 1'b0;
   logic          rst_n    = 1'b0;
   logic [NW-1:0] div_int  = 8'd4;
   logic [AW-1:0] frac_k   = '0;
   logic [AW-1:0] acc_mod  = 10'd5;
   logic          div_clk;
   logic          ovf_sel;
   logic [NW:0]   cycles_left;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int acc_m = 0;

   always #5 clk_fast = ~clk_fast;

   fracn_divider #(.NW(NW), .AW(AW)) dut_i (
      .clk_fast    (clk_fast),
      .rst_n       (rst_n),
      .div_int     (div_int),
      .frac_k      (frac_k),
      .acc_mod     (acc_mod),
      .div_clk     (div_clk),
      .ovf_sel     (ovf_sel),
      .cycles_left (cycles_left)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_acc(input int a, input int k, input int f);
      return (a + k >= f) ? a + k - f : a + k;
   endfunction

   task automatic do_reset(input int n, input int k, input int f);
      @(negedge clk_fast);
      rst_n = 1'b0;
      div_int = n[NW-1:0]; frac_k = k[AW-1:0]; acc_mod = f[AW-1:0];
      repeat (3) @(negedge clk_fast);
      check(div_clk == 1'b1 && cycles_left == 0 && ovf_sel == 1'b0,
            "R1 in reset", {div_clk, ovf_sel, 9'(cycles_left)}, 1024);
      rst_n = 1'b1;
      acc_m = 0;
      check(div_clk == 1'b1 && cycles_left == 0 && ovf_sel == 1'b0,
            "R1 after release", {div_clk, ovf_sel, 9'(cycles_left)}, 1024);
   endtask

   // called at a load-cycle negedge with the real inputs applied
   task automatic run_cfg(input int n, input int k, input int f, input int periods,
                          input string tag);
      int longs = 0;
      int in_win = 0;
      for (int p = 0; p < periods; p++) begin
         bit ov = (acc_m + k >= f);
         int len = n + int'(ov);
         int cnt_err = 0;
         acc_m = next_acc(acc_m, k, f);
         longs += int'(ov);
         for (int j = 1; j <= len; j++) begin
            @(negedge clk_fast);
            if (j == 1)
               check(ovf_sel == ov, {"R3 select ", tag}, int'(ovf_sel), int'(ov));
            if (j < len) begin
               if (cycles_left != (NW+1)'(len - j) || div_clk) cnt_err++;
               // R7: noise on inputs outside the load cycle
               div_int = NW'($urandom);
               frac_k  = AW'($urandom);
               acc_mod = AW'($urandom);
            end else begin
               div_int = n[NW-1:0]; frac_k = k[AW-1:0]; acc_mod = f[AW-1:0];
            end
         end
         check(div_clk == 1'b1 && cycles_left == 0 && cnt_err == 0,
               {"R2 R8 R7 period length ", tag}, cnt_err, 0);
         in_win++;
         if (in_win == f) begin
            check(longs == k, {"R5 long count per window ", tag}, longs, k);
            longs = 0;
            in_win = 0;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      // R6: integer-N
      do_reset(4, 0, 5);
      run_cfg(4, 0, 5, 10, "R6 k0");
      // R9: K = F-1 at minimum N
      do_reset(4, 4, 5);
      run_cfg(4, 4, 5, 10, "R9 kmax");
      // R4: remainder carried across wrap (3rd, 6th, 8th long)
      do_reset(7, 3, 8);
      run_cfg(7, 3, 8, 16, "R4 k3f8");
      // wide modulus, large N
      do_reset(200, 17, 40);
      run_cfg(200, 17, 40, 40, "wide");
      for (int s = 0; s < 6; s++) begin
         int n = 4 + int'($urandom % 60);
         int f = 2 + int'($urandom % 40);
         int k = int'($urandom % f);
         do_reset(n, k, f);
         run_cfg(n, k, f, 2 * f, "random");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_fast);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule